// File: doc/BRIEF.md
# PPM Frame Servo Demultiplexer

This block splits a single-wire pulse-position stream, as it appears after the radio stage of a hobby receiver, into one servo control line per output channel. Each frame opens with a long gap. After the gap the channels follow one after another. Each channel is a variable-length active stretch followed by a short fixed inactive stretch. An optional inversion brings either brand polarity to an active-high form before decoding.

The line is synchronised and glitch-filtered. A gap timer, driven by a one-microsecond tick, declares a frame start once the line has been inactive long enough. A one-hot token is cleared at that point. The next active-going edge places the token on output 0, and each later edge moves it one output up. The selected output stays high across its channel's whole period, active plus inactive portion.

A transmitter with fewer channels than the receiver leaves the upper outputs low. A transmitter with more channels pushes the token off the end, and the surplus pulses do nothing until the next gap. At every frame start, the number of edges seen in the frame just ended is published.

Top module: `ppm_servo_demux`

## Requirements
- R1: With `invert` = 0 a high `ppm_in` is the active level; with `invert` = 1 a low `ppm_in` is the active level, and decoding is otherwise identical.
- R2: `ppm_in` passes a two-flop synchroniser and a filter that accepts a new level only after two consecutive equal samples; a high or low spike lasting one clock has no effect on any output.
- R3: At most one bit of `servo_out` is high at any time.
- R4: `frame_start` pulses high for exactly one clock once the filtered line has stayed inactive for `SYNC_US` ticks of `us_tick`; an inactive stretch shorter than that (such as the inter-channel gap) never produces it, and one gap produces it once.
- R5: In the cycle `frame_start` is high, all `servo_out` bits are low.
- R6: The first active-going edge after a frame start drives `servo_out[0]` high; each further edge moves the high bit from index k to k+1; the high bit stays high through the inactive portion and, for the last channel, until the next frame start.
- R7: When fewer channels than `NUM_OUT` arrive, the outputs above the last received channel stay low for the whole frame.
- R8: When more channels than `NUM_OUT` arrive, all outputs are low from the edge after channel `NUM_OUT` until the next frame start, and the surplus edges move nothing.
- R9: At each frame start, `chan_count` takes the number of active-going edges since the previous frame start, saturating at 15, and holds it until the next frame start; edges before the first frame start after reset are not counted.
- R10: After reset, `servo_out`, `frame_start` and `chan_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ppm_in | input | 1 | Raw pulse-position stream, asynchronous |
| invert | input | 1 | 1 selects an active-low stream |
| us_tick | input | 1 | One-clock strobe once per microsecond |
| servo_out | output | NUM_OUT | One servo control line per channel |
| frame_start | output | 1 | One-clock strobe at each detected frame gap |
| chan_count | output | 4 | Channels seen in the last completed frame |

## Verification
Glitch rejection and gap timing can act in the same stretch of time. A one-clock active spike that lands inside a running frame gap must neither restart the gap timer nor count as a channel edge. The bench injects such a spike in the middle of a gap. It then checks three things: `frame_start` still appears within the expected window, the published channel count still equals the channels actually sent, and all outputs stay low around the spike.

// File: rtl/ppm_pkg.sv
// Shared constants for the PPM demultiplexer.
// Assumes the channel counter is four bits wide, so it saturates at 15.
package ppm_pkg;
    localparam int CNT_W   = 4;
    localparam int CNT_MAX = (1 << CNT_W) - 1;
endpackage

// File: rtl/ppm_line_cond.sv
// Line conditioner: applies the polarity select, synchronises the raw stream
// with two flops, and keeps a level only after two equal consecutive samples.
// Assumes ppm_in is asynchronous to clk and that invert changes only together
// with the line's polarity. Latency is four clocks from ppm_in to level.
module ppm_line_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic ppm_in,
    input  logic invert,
    output logic level,
    output logic rise
);
    logic sync1_q, sync2_q, samp_q, lvl_q, lvl_prev_q;

    // Synchroniser, sample history, filtered level and its delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q    <= 1'b0;
            sync2_q    <= 1'b0;
            samp_q     <= 1'b0;
            lvl_q      <= 1'b0;
            lvl_prev_q <= 1'b0;
        end else begin
            sync1_q    <= ppm_in ^ invert;
            sync2_q    <= sync1_q;
            samp_q     <= sync2_q;
            if (sync2_q == samp_q)
                lvl_q  <= sync2_q;
            lvl_prev_q <= lvl_q;
        end
    end

    // Active-going edge of the filtered line.
    always_comb begin
        level = lvl_q;
        rise  = lvl_q & ~lvl_prev_q;
    end

    // The filtered level may only move after two agreeing samples.
    assert_filter_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lvl_q) |-> $past(sync2_q == samp_q));
endmodule

// File: rtl/ppm_gap_timer.sv
// Gap timer: counts microsecond ticks while the filtered line is inactive
// and flags a frame gap once SYNC_US ticks have elapsed.
// Assumes us_tick is a single-clock strobe. The count saturates, so each
// gap raises gap_hit only once.
module ppm_gap_timer #(
    parameter int SYNC_US = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic us_tick,
    output logic gap_hit
);
    localparam int GAP_W = $clog2(SYNC_US + 1);
    localparam logic [GAP_W-1:0] LIMIT = GAP_W'(SYNC_US);
    localparam logic [GAP_W-1:0] LAST  = GAP_W'(SYNC_US - 1);

    logic [GAP_W-1:0] gap_q;

    // Elapsed inactive time, cleared by the active level, held at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= '0;
        else if (level)
            gap_q <= '0;
        else if (us_tick && gap_q != LIMIT)
            gap_q <= gap_q + 1'b1;
    end

    // Fires on the tick that completes the required gap.
    always_comb gap_hit = !level && us_tick && (gap_q == LAST);

    assert_gap_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= LIMIT);
endmodule

// File: rtl/ppm_token_steer.sv
// Token steering: a one-hot token, cleared at each frame gap, that moves one
// output up on every active-going edge. It also keeps a saturating edge count
// that is published at each gap. Assumes gap_hit and rise never coincide:
// gap_hit needs the inactive level and rise needs the active level.
module ppm_token_steer
    import ppm_pkg::*;
#(
    parameter int NUM_OUT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rise,
    input  logic               gap_hit,
    output logic [NUM_OUT-1:0] token,
    output logic               frame_start,
    output logic [CNT_W-1:0]   chan_count
);
    logic [NUM_OUT-1:0] token_q;
    logic [CNT_W-1:0]   run_q, count_q;
    logic               locked_q, strobe_q;

    // Frame sequencing: reload at the gap, step the token on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            token_q  <= '0;
            run_q    <= '0;
            count_q  <= '0;
            locked_q <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= gap_hit;
            if (gap_hit) begin
                count_q  <= run_q;
                run_q    <= '0;
                token_q  <= '0;
                locked_q <= 1'b1;
            end else if (rise && locked_q) begin
                if (run_q != CNT_W'(CNT_MAX))
                    run_q <= run_q + 1'b1;
                if (run_q == '0)
                    token_q <= NUM_OUT'(1);
                else
                    token_q <= token_q << 1;
            end
        end
    end

    // Registered state to ports.
    always_comb begin
        token       = token_q;
        frame_start = strobe_q;
        chan_count  = count_q;
    end

    assert_token_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(token_q));
    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |=> !strobe_q);
    assert_clear_on_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |-> token_q == '0);
    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && locked_q && !gap_hit && run_q != CNT_W'(CNT_MAX))
        |=> run_q == $past(run_q) + 1'b1);
endmodule

// File: rtl/ppm_servo_demux.sv
// PPM frame servo demultiplexer top: conditions the input line, times frame
// gaps and steers a one-hot token across NUM_OUT servo outputs.
// Assumes us_tick marks microseconds and that NUM_OUT does not exceed 15.
module ppm_servo_demux
    import ppm_pkg::*;
#(
    parameter int NUM_OUT = 8,
    parameter int SYNC_US = 3000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ppm_in,
    input  logic               invert,
    input  logic               us_tick,
    output logic [NUM_OUT-1:0] servo_out,
    output logic               frame_start,
    output logic [CNT_W-1:0]   chan_count
);
    logic level, rise, gap_hit;

    ppm_line_cond u_cond (
        .clk    (clk),
        .rst_n  (rst_n),
        .ppm_in (ppm_in),
        .invert (invert),
        .level  (level),
        .rise   (rise)
    );

    ppm_gap_timer #(.SYNC_US(SYNC_US)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (level),
        .us_tick (us_tick),
        .gap_hit (gap_hit)
    );

    ppm_token_steer #(.NUM_OUT(NUM_OUT)) u_steer (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise        (rise),
        .gap_hit     (gap_hit),
        .token       (servo_out),
        .frame_start (frame_start),
        .chan_count  (chan_count)
    );
endmodule

// File: tb/ppm_servo_demux_bench.sv
module ppm_servo_demux_bench;
    localparam int NOUT = 4;
    localparam int SYNC = 20;
    localparam int TDIV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ppm_in = 1'b0;
    logic invert = 1'b0;
    logic us_tick = 1'b0;
    logic [NOUT-1:0] servo_out;
    logic frame_start;
    logic [3:0] chan_count;

    int checks = 0;
    int fails = 0;
    int frames = 0;
    int cycles = 0;
    logic fs_prev = 1'b0;
    logic pol = 1'b0;

    ppm_servo_demux #(.NUM_OUT(NOUT), .SYNC_US(SYNC)) u_ppm_servo_demux (
        .clk(clk), .rst_n(rst_n), .ppm_in(ppm_in), .invert(invert),
        .us_tick(us_tick), .servo_out(servo_out),
        .frame_start(frame_start), .chan_count(chan_count)
    );

    always #4 clk = ~clk;

    initial begin
        forever begin
            for (int k = 0; k < TDIV; k++) begin
                @(negedge clk);
                us_tick = (k == 0);
            end
        end
    end

    // Strobe monitor: counts frame starts and checks the one-clock width.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (frame_start) frames++;
            if (frame_start && fs_prev) begin
                fails++;
                $display("FAIL R4 frame_start wider than one clock: actual 1 expected 0");
            end
            if (frame_start && servo_out != '0) begin
                fails++;
                $display("FAIL R5 outputs at frame_start: actual %b expected 0", servo_out);
            end
            checks++;
        end
        fs_prev = frame_start;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic active);
        @(negedge clk);
        invert = pol;
        ppm_in = active ^ pol;
    endtask

    task automatic wait_us(input int us);
        repeat (us * TDIV) @(negedge clk);
    endtask

    // One frame of nch channels followed by a long gap; optional mid-gap spike.
    task automatic send_frame(input int nch, input bit spike);
        int f0;
        int expl;
        for (int i = 0; i < nch; i++) begin
            int exp = (i < NOUT) ? (1 << i) : 0;
            drive(1'b1);
            wait_us(3);
            chk((i < NOUT) ? "R6 channel active part" : "R8 surplus channel",
                servo_out, exp);
            wait_us(3 + 2 * (i % 5));
            drive(1'b0);
            wait_us(2);
            chk("R6 channel inactive part", servo_out, exp);
            wait_us(2);
        end
        f0 = frames;
        expl = (nch <= NOUT) ? (1 << (nch - 1)) : 0;
        wait_us(2);
        chk("R6 last channel held into gap", servo_out, expl);
        if (nch < NOUT)
            chk("R7 unused outputs low", servo_out >> nch, 0);
        chk("R4 no sync inside frame", frames - f0, 0);
        wait_us(8);
        if (spike) begin
            @(negedge clk);
            ppm_in = 1'b1 ^ pol;
            @(negedge clk);
            ppm_in = 1'b0 ^ pol;
            wait_us(1);
            chk("R2 spike ignored by outputs", servo_out, expl);
        end
        wait_us(2);
        chk("R4 no early sync", frames - f0, 0);
        wait_us(18);
        chk("R4 one sync per gap", frames - f0, 1);
        chk("R5 outputs cleared after gap", servo_out, 0);
        chk("R9 channel count", chan_count, (nch > 15) ? 15 : nch);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk("R10 reset servo_out", servo_out, 0);
        chk("R10 reset frame_start", frame_start, 0);
        chk("R10 reset chan_count", chan_count, 0);
        rst_n = 1'b1;
        // Edges before the first frame start are ignored (R9).
        for (int j = 0; j < 2; j++) begin
            drive(1'b1);
            wait_us(3);
            chk("R9 pre-sync edge ignored", servo_out, 0);
            drive(1'b0);
            wait_us(3);
        end
        wait_us(30);
        chk("R4 first sync seen", frames, 1);
        chk("R9 pre-sync edges not counted", chan_count, 0);
        // Sweep channel counts and both polarities (R1).
        for (int p = 0; p < 2; p++) begin
            pol = p[0];
            drive(1'b0);
            wait_us(30);
            for (int n = 1; n <= NOUT + 2; n++)
                send_frame(n, 1'b0);
            chk("R1 polarity sweep done", 1, 1);
        end
        // Mid-gap spike together with gap timing (R2, R4).
        send_frame(3, 1'b1);
        send_frame(NOUT + 1, 1'b1);
        // Count saturation (R9).
        send_frame(16, 1'b0);
        send_frame(2, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule